// File: doc/BRIEF.md
# Period-Measuring Interval Timer

This block is a 16-bit timer with two operating modes, driven from a small word-wide register bus. In timer mode it is an up-counter that software may load at any time. It has a companion limit register that acts as a compare value and raises a match flag whenever the two are equal. The count source is picked by a 3-bit select field. It is either one of seven prescaled clock-enable strobes supplied from outside, or edges of an external clock pin, rising or falling as chosen.

In period mode the same counter times the interval between two consecutive chosen edges of a measured input pin. The first chosen edge zeroes the counter. Every later chosen edge closes the running period: it copies the count into a capture register and restarts the count at zero. The limit register then serves as an upper bound, and a sticky over-limit flag marks any captured period that is strictly larger than it. Both pins are resynchronised with a two-flop chain before their edges are detected, so each edge becomes a one-cycle enable in the system clock domain.

Top module: `cyc_timer`

## Requirements
- R1: After synchronous reset the control word reads 0x0000, status 0x0000, counter 0x0000, limit 0xFFFF and capture 0x0000.
- R2: Control bit 4 (run) enables counting, and bits 2:0 pick the source. Values 0 to 6 count one step per cycle in which presc_en[select] is high. Value 7 counts synchronised ext_clk edges, rising edges when control bit 3 is 0 and falling edges when it is 1.
- R3: A counting step that takes the counter from 0xFFFF to 0x0000 sets status bit 0 (overflow).
- R4: In timer mode (control bit 5 = 0), a control write that changes run from 1 to 0 resets the counter to 0x0000.
- R5: In timer mode a counter write loads the written value, taking priority over a counting step. In period mode (control bit 5 = 1) counter writes are ignored.
- R6: In period mode with run set, the first chosen meas_in edge zeroes the counter. Each later chosen edge copies the counter into the capture register and zeroes the counter. Control bit 6 picks the edge: 0 for rising, 1 for falling. When the counter steps every cycle, a period of P cycles captures P-1.
- R7: When a capture is strictly greater than the limit register, status bit 2 (over-limit) is set. A capture equal to the limit leaves it unchanged.
- R8: In timer mode, status bit 1 (match) is set in any cycle where the counter equals the limit register, except a cycle in which the limit register is written.
- R9: Status bits are sticky. Writing 0 to a bit clears it and writing 1 leaves it alone. A set condition in the same cycle as a clear wins.
- R10: Registers are whole 16-bit words at bus_addr 0 (control), 1 (status), 2 (counter), 3 (limit) and 4 (capture). bus_rdata shows the addressed register combinationally. The capture register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| presc_en | input | 7 | Prescaled count-enable strobes, one per select value 0 to 6 |
| ext_clk | input | 1 | External count clock, asynchronous |
| meas_in | input | 1 | Waveform whose period is measured, asynchronous |

## Verification
The bound checker watches, on every cycle, several rules that must always hold. A wrap step must raise the overflow flag. Stopping in timer mode and every period-boundary edge must zero the counter. A counter write in period mode must leave it stable. A limit write must never raise the match flag. An equal compare must win over a clearing write. A raised over-limit flag must pair with a capture larger than the limit. Only the bench scenarios can show the quantities themselves. These are counts of external-clock edges in each polarity, exact captured periods under both edge choices, the limit boundary at equality, and that the capture register is read-only through the bus.

// File: rtl/cyc_timer_pkg.sv
// Shared constants and types for the period-measuring timer.
// Assumes a 16-bit data path and a 3-bit count-source select.
package cyc_timer_pkg;
    localparam int DW      = 16;
    localparam int AW      = 3;
    localparam int SEL_W   = 3;
    localparam int NSRC    = 2 ** SEL_W;
    localparam int NPRE    = NSRC - 1;
    localparam int NFLAG   = 3;

    // Register word addresses
    localparam logic [AW-1:0] ADR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADR_STAT = 3'd1;
    localparam logic [AW-1:0] ADR_CNT  = 3'd2;
    localparam logic [AW-1:0] ADR_LIM  = 3'd3;
    localparam logic [AW-1:0] ADR_CAP  = 3'd4;

    // Control bit positions
    localparam int CB_XFALL = 3;
    localparam int CB_RUN   = 4;
    localparam int CB_CYC   = 5;
    localparam int CB_MFALL = 6;

    // Status bit positions
    localparam int SB_OVF = 0;
    localparam int SB_CMF = 1;
    localparam int SB_OVL = 2;

    typedef struct packed {
        logic             mfall;
        logic             cyc;
        logic             run;
        logic             xfall;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cyc_timer_edge.sv
// Resynchronises an asynchronous pin and turns its chosen edge into a
// one-cycle pulse. Assumes the pin stays at each level for at least two
// system clock cycles so no edge is lost.
module cyc_timer_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    // stages 0..LAST form the synchroniser, stage SYNC_STAGES keeps history
    logic [SYNC_STAGES:0] sh_q;

    // shift the pin through the synchroniser and history stage
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
    end

    // pick the rising or falling transition of the synchronised level
    always_comb begin
        if (fall_sel) pulse = ~sh_q[LAST] &  sh_q[SYNC_STAGES];
        else          pulse =  sh_q[LAST] & ~sh_q[SYNC_STAGES];
    end
endmodule

// File: rtl/cyc_timer_src.sv
// Count-source multiplexer: select values below the top one pick a
// prescaler strobe, the top value picks the external-clock edge pulse.
module cyc_timer_src
    import cyc_timer_pkg::*;
(
    input  logic [NPRE-1:0]  presc_en,
    input  logic             ext_pulse,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [NSRC-1:0] srcs;

    // gather every candidate source and index it by the select field
    always_comb begin
        srcs = {ext_pulse, presc_en};
        tick = srcs[sel];
    end
endmodule

// File: rtl/cyc_timer_core.sv
// Counter, period capture and flag-event logic. Assumes the tick and the
// measured-edge pulse are single-cycle enables in the clk domain.
// Counter priority: period edge, stop clear, bus load, count step.
module cyc_timer_core
    import cyc_timer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cyc,
    input  logic          tick,
    input  logic          meas_pulse,
    input  logic          cnt_we,
    input  logic [DW-1:0] cnt_wdata,
    input  logic          stop_clr,
    input  logic [DW-1:0] lim,
    input  logic          lim_we,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cap,
    output logic          ev_ovf,
    output logic          ev_cmf,
    output logic          ev_ovl
);
    logic [DW-1:0] cnt_q, cnt_nxt, cap_q;
    logic          armed_q, wrap;
    logic          cyc_act, boundary, closing;

    assign cyc_act  = run & cyc;
    assign boundary = cyc_act & meas_pulse;
    assign closing  = boundary & armed_q;

    // choose the next counter value and spot a wrap step
    always_comb begin
        cnt_nxt = cnt_q;
        wrap    = 1'b0;
        if (boundary)               cnt_nxt = '0;
        else if (!cyc && stop_clr)  cnt_nxt = '0;
        else if (!cyc && cnt_we)    cnt_nxt = cnt_wdata;
        else if (run && tick) begin
            cnt_nxt = cnt_q + DW'(1);
            wrap    = &cnt_q;
        end
    end

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // remember that the first boundary edge has been seen
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (!cyc_act) armed_q <= 1'b0;
        else if (boundary) armed_q <= 1'b1;
    end

    // latch the finished period length
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (closing) cap_q <= cnt_q;
    end

    assign ev_ovf = wrap;
    assign ev_cmf = !cyc && !lim_we && (cnt_q == lim);
    assign ev_ovl = closing && (cnt_q > lim);
    assign cnt    = cnt_q;
    assign cap    = cap_q;
endmodule

// File: rtl/cyc_timer.sv
// Top of the period-measuring timer: register bus decode, control, limit
// and sticky status registers around the counter core. Assumes one bus
// access per cycle and whole-word writes only.
module cyc_timer
    import cyc_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPRE-1:0] presc_en,
    input  logic            ext_clk,
    input  logic            meas_in
);
    ctrl_t            ctrl_q;
    logic [DW-1:0]    lim_q, cnt_w, cap_w;
    logic [NFLAG-1:0] flag_q, flag_ev;
    logic             ctrl_we, stat_we, cnt_we, lim_we, stop_clr;
    logic             ext_pulse, meas_pulse, tick_w;
    logic             ev_ovf, ev_cmf, ev_ovl;

    assign ctrl_we = bus_we && (bus_addr == ADR_CTRL);
    assign stat_we = bus_we && (bus_addr == ADR_STAT);
    assign cnt_we  = bus_we && (bus_addr == ADR_CNT);
    assign lim_we  = bus_we && (bus_addr == ADR_LIM);
    assign stop_clr = ctrl_we && ctrl_q.run && !bus_wdata[CB_RUN] && !bus_wdata[CB_CYC];

    cyc_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk),
        .fall_sel(ctrl_q.xfall), .pulse(ext_pulse)
    );

    cyc_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_meas (
        .clk(clk), .rst_n(rst_n), .pin(meas_in),
        .fall_sel(ctrl_q.mfall), .pulse(meas_pulse)
    );

    cyc_timer_src u_src (
        .presc_en(presc_en), .ext_pulse(ext_pulse),
        .sel(ctrl_q.sel), .tick(tick_w)
    );

    cyc_timer_core u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .cyc(ctrl_q.cyc),
        .tick(tick_w), .meas_pulse(meas_pulse), .cnt_we(cnt_we),
        .cnt_wdata(bus_wdata), .stop_clr(stop_clr), .lim(lim_q),
        .lim_we(lim_we), .cnt(cnt_w), .cap(cap_w),
        .ev_ovf(ev_ovf), .ev_cmf(ev_cmf), .ev_ovl(ev_ovl)
    );

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // limit / compare register
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_q <= '1;
        else if (lim_we) lim_q <= bus_wdata;
    end

    // map flag events onto status bit positions
    always_comb begin
        flag_ev         = '0;
        flag_ev[SB_OVF] = ev_ovf;
        flag_ev[SB_CMF] = ev_cmf;
        flag_ev[SB_OVL] = ev_ovl;
    end

    // sticky status flags, set wins over a write-zero clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else begin
            for (int i = 0; i < NFLAG; i++) begin
                if (flag_ev[i])                    flag_q[i] <= 1'b1;
                else if (stat_we && !bus_wdata[i]) flag_q[i] <= 1'b0;
            end
        end
    end

    // read multiplexer
    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            ADR_STAT: bus_rdata = {{(DW-NFLAG){1'b0}}, flag_q};
            ADR_CNT:  bus_rdata = cnt_w;
            ADR_LIM:  bus_rdata = lim_q;
            ADR_CAP:  bus_rdata = cap_w;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cyc_timer_chk.sv
// Property checker for cyc_timer, attached by bind below.
// Observes bus strokes, control bits, counter, limit, capture and flags.
module cyc_timer_chk
    import cyc_timer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic             wd_run,
    input logic             wd_cyc,
    input logic             wd_ovl,
    input logic             run,
    input logic             cyc,
    input logic [DW-1:0]    cnt_q,
    input logic [DW-1:0]    lim_q,
    input logic [DW-1:0]    cap_q,
    input logic [NFLAG-1:0] flags,
    input logic             tick,
    input logic             meas_pulse,
    input logic             stop_clr
);
    logic cnt_wr, lim_wr, ctrl_wr, stat_wr;
    assign cnt_wr  = bus_we && (bus_addr == ADR_CNT);
    assign lim_wr  = bus_we && (bus_addr == ADR_LIM);
    assign ctrl_wr = bus_we && (bus_addr == ADR_CTRL);
    assign stat_wr = bus_we && (bus_addr == ADR_STAT);

    p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 16'hFFFF && run && tick && !(cyc && meas_pulse)
         && !(!cyc && cnt_wr) && !stop_clr) |=> flags[SB_OVF]);

    p_stop_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && run && !wd_run && !wd_cyc) |=> (cnt_q == '0));

    p_cyc_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && cnt_wr && !meas_pulse && !(run && tick)) |=> $stable(cnt_q));

    p_edge_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && run && meas_pulse) |=> (cnt_q == '0));

    p_ovl_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags[SB_OVL]) && !$past(lim_wr)) |-> (cap_q > lim_q));

    p_lim_wr_nomatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && !flags[SB_CMF]) |=> !flags[SB_CMF]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc && !lim_wr && cnt_q == lim_q) |=> flags[SB_CMF]);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[SB_OVL] && !(stat_wr && !wd_ovl)) |=> flags[SB_OVL]);
endmodule

bind cyc_timer cyc_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .wd_run(bus_wdata[cyc_timer_pkg::CB_RUN]),
    .wd_cyc(bus_wdata[cyc_timer_pkg::CB_CYC]),
    .wd_ovl(bus_wdata[cyc_timer_pkg::SB_OVL]),
    .run(ctrl_q.run), .cyc(ctrl_q.cyc), .cnt_q(cnt_w), .lim_q(lim_q),
    .cap_q(cap_w), .flags(flag_q), .tick(tick_w),
    .meas_pulse(meas_pulse), .stop_clr(stop_clr)
);

// File: tb/sim_cyc_timer.sv
// Scoreboard bench: driver tasks queue expected register contents, a
// monitor pops and compares them one cycle later, away from the edge.
module sim_cyc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [6:0]  presc_en = '0;
    logic        ext_clk = 1'b0;
    logic        meas_in = 1'b0;

    typedef struct {
        logic [15:0] exp;
        logic [15:0] mask;
        string       tag;
    } item_t;

    item_t q[$];
    logic  req = 1'b0;
    logic  done = 1'b0;
    int    total = 0;
    int    bad = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CNT = 3'd2,
                           A_LIM = 3'd3, A_CAP = 3'd4;

    always #4 clk = ~clk;

    cyc_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_en(presc_en),
        .ext_clk(ext_clk), .meas_in(meas_in)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [15:0] e,
                       input logic [15:0] m, input string tag);
        item_t it;
        it.exp = e; it.mask = m; it.tag = tag;
        bus_addr = a;
        q.push_back(it);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    // monitor: compare the queued expectation after the next edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (req && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
                    bad++;
                    $display("FAIL %s: got=%h exp=%h", it.tag,
                             bus_rdata & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values
        chk(A_CTRL, 16'h0000, 16'hFFFF, "R1 ctrl");
        chk(A_STAT, 16'h0000, 16'hFFFF, "R1 stat");
        chk(A_CNT,  16'h0000, 16'hFFFF, "R1 cnt");
        chk(A_LIM,  16'hFFFF, 16'hFFFF, "R1 lim");
        chk(A_CAP,  16'h0000, 16'hFFFF, "R1 cap");

        // R2 external clock, rising then falling edges
        wr(A_CTRL, 16'h0017);
        for (int i = 0; i < 5; i++) begin
            ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3);
        end
        idle(4);
        chk(A_CNT, 16'd5, 16'hFFFF, "R2 ext rising");
        wr(A_CTRL, 16'h001F);
        for (int i = 0; i < 3; i++) begin
            ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3);
        end
        idle(4);
        chk(A_CNT, 16'd8, 16'hFFFF, "R2 ext falling");

        // R4 stop clears the counter
        wr(A_CTRL, 16'h0007);
        chk(A_CNT, 16'd0, 16'hFFFF, "R4 stop clear");

        // R2 prescaler select: idle strobe gives no count, live strobe counts
        presc_en = 7'b0000001;
        wr(A_CTRL, 16'h0012);
        idle(10);
        chk(A_CNT, 16'd0, 16'hFFFF, "R2 idle strobe");
        wr(A_CTRL, 16'h0000);
        wr(A_CTRL, 16'h0010);
        idle(9);
        chk(A_CNT, 16'd10, 16'hFFFF, "R2 strobe count");
        wr(A_CTRL, 16'h0000);

        // R5 timer-mode load
        wr(A_CNT, 16'h1234);
        chk(A_CNT, 16'h1234, 16'hFFFF, "R5 load");

        // R3 overflow on wrap
        wr(A_CNT, 16'hFFFD);
        chk(A_STAT, 16'h0000, 16'h0001, "R3 no ovf before wrap");
        wr(A_CTRL, 16'h0010);
        idle(5);
        chk(A_STAT, 16'h0001, 16'h0001, "R3 ovf after wrap");
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0000);
        chk(A_STAT, 16'h0000, 16'hFFFF, "R9 clear by zero");

        // R8 compare match
        wr(A_LIM, 16'd5);
        wr(A_CNT, 16'd3);
        chk(A_STAT, 16'h0000, 16'h0002, "R8 no match");
        wr(A_CNT, 16'd5);
        chk(A_STAT, 16'h0002, 16'h0002, "R8 match");

        // R9 set beats clear
        wr(A_STAT, 16'h0000);
        chk(A_STAT, 16'h0002, 16'h0002, "R9 set wins");
        wr(A_LIM, 16'h0100);
        wr(A_STAT, 16'h0000);
        chk(A_STAT, 16'h0000, 16'h0002, "R9 cleared");

        // R8 no match in the limit-write cycle
        wr(A_LIM, 16'd102);
        wr(A_STAT, 16'h0000);
        wr(A_CTRL, 16'h0010);
        wr(A_CNT, 16'd100);
        idle(2);
        wr(A_LIM, 16'h0500);
        wr(A_CTRL, 16'h0000);
        chk(A_STAT, 16'h0000, 16'h0002, "R8 suppressed on limit write");

        // R5 counter write ignored in period mode
        wr(A_CTRL, 16'h0020);
        wr(A_CNT, 16'h4321);
        chk(A_CNT, 16'h0000, 16'hFFFF, "R5 period-mode write ignored");

        // R6 / R7 period measurement, rising edges
        wr(A_LIM, 16'd50);
        wr(A_CTRL, 16'h0030);
        meas_in = 1'b1; idle(10); meas_in = 1'b0; idle(30);
        meas_in = 1'b1; idle(10); meas_in = 1'b0; idle(39);
        chk(A_CAP, 16'd39, 16'hFFFF, "R6 period 40");
        chk(A_STAT, 16'h0000, 16'h0004, "R7 under limit");
        meas_in = 1'b1; idle(10); meas_in = 1'b0; idle(68);
        chk(A_CAP, 16'd50, 16'hFFFF, "R6 period 51");
        chk(A_STAT, 16'h0000, 16'h0004, "R7 equal not over");
        meas_in = 1'b1; idle(10); meas_in = 1'b0;
        idle(2);
        chk(A_CAP, 16'd79, 16'hFFFF, "R6 period 80");
        chk(A_STAT, 16'h0004, 16'h0004, "R7 over limit");

        // R6 falling-edge period
        wr(A_CTRL, 16'h0020);
        wr(A_CTRL, 16'h0070);
        meas_in = 1'b1; idle(5); meas_in = 1'b0; idle(20);
        meas_in = 1'b1; idle(5); meas_in = 1'b0; idle(10);
        chk(A_CAP, 16'd24, 16'hFFFF, "R6 falling period 25");

        // R10 capture is read-only, limit reads back
        wr(A_CAP, 16'hAAAA);
        chk(A_CAP, 16'd24, 16'hFFFF, "R10 capture read-only");
        chk(A_LIM, 16'd50, 16'hFFFF, "R10 limit readback");

        idle(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule